// File: doc/BRIEF.md
# Diagnostic Test-Output Selector with Feedback Counter

This block drives one diagnostic output pin of a clock synthesizer, picking its source with a 3-bit test code. The block holds the digital dividers around the loop. A 9-bit feedback counter gives a one-cycle pulse every M input ticks. A divide-by-16 prescaler works on the reference. A post divider with ratios 1, 2, 4 and 8 makes the synthesized output. A further divide-by-4 stage follows it. The analog loop is outside the block. The oscillator, the reference and the serial programming clock arrive as one-cycle tick strobes in the block's own clock domain.

One test code selects a bypass mode. In that mode the serial-clock ticks replace the oscillator ticks as the input to both the feedback counter and the post divider. The post divider still drives the main output, and the counter's pulse train appears on the diagnostic pin. This lets a board be stepped at low speed through its clock tree. The diagnostic pin is registered, so a change of test code changes the pin only at a clock edge.

Top module: `testsel_top`

## Requirements
- R1: After reset, `fout` and `testOut` are both 0.
- R2: Test code 3'b000 passes `shiftBit` to `testOut` with one clock of delay.
- R3: Test code 3'b001 drives `testOut` to 1 and test code 3'b101 drives it to 0, starting one clock after the code is applied.
- R4: Test code 3'b010 shows the reference prescaled by 16: a level that toggles once every 8 `refEn` ticks.
- R5: With `mDiv` = M ≥ 1, the feedback counter emits one pulse, one clock wide, for every M oscillator ticks. Test code 3'b011 shows this pulse on `testOut`. With M = 1 and a tick on every clock the pin stays high.
- R6: With `mDiv` = 0 the feedback counter emits no pulse.
- R7: `fout` toggles once every R post-divider ticks, where R is 1, 2, 4 or 8 for `nSel` = 0, 1, 2, 3.
- R8: Test code 3'b100 shows `fout` on `testOut`. Test code 3'b111 shows `fout` divided by 4, which toggles on every second rising edge of `fout`.
- R9: With test code 3'b110 (bypass), only `sclkEn` ticks advance the feedback counter and the post divider. `vcoEn` has no effect, and `testOut` carries the counter pulse.
- R10: With any test code other than 3'b110, `sclkEn` ticks advance neither the counter nor the post divider.
- R11: `testOut` is registered. A new test code never shows on the pin before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| vcoEn | input | 1 | Oscillator tick strobe |
| refEn | input | 1 | Reference tick strobe |
| sclkEn | input | 1 | Serial programming clock tick strobe |
| shiftBit | input | 1 | Serial bit leaving the configuration shift register |
| testCode | input | 3 | Diagnostic source select |
| mDiv | input | 9 | Feedback count M (0 = silent) |
| nSel | input | 2 | Post-divider ratio select |
| fout | output | 1 | Synthesized output level |
| testOut | output | 1 | Registered diagnostic output |

## Verification
The oscillator tick and the serial-clock tick can reach the dividers in the same cycle. In bypass, the block must take only the serial tick and drop the other. The bench holds `vcoEn` high on every clock and pulses `sclkEn` on every other clock. It then counts the `fout` toggles and the counter pulses, and both must match the serial tick count alone. The reverse case puts serial ticks alone into normal mode, and both counts must stay at zero.

// File: rtl/testsel_pkg.sv
package testsel_pkg;

  typedef enum logic [2:0] {
    TC_SHIFT  = 3'b000,
    TC_ONE    = 3'b001,
    TC_REF16  = 3'b010,
    TC_MCOUNT = 3'b011,
    TC_FOUT   = 3'b100,
    TC_ZERO   = 3'b101,
    TC_BYPASS = 3'b110,
    TC_FOUT4  = 3'b111
  } test_code_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic refTick;
    logic mTick;
    logic nTick;
  } div_strobe_t;

endpackage

// File: rtl/testsel_ctrl.sv
module testsel_ctrl
  import testsel_pkg::*;
(
  input  logic        vcoEn,
  input  logic        refEn,
  input  logic        sclkEn,
  input  logic [2:0]  testCode,
  output div_strobe_t strobes
);

  logic bypassOn;

  always_comb begin
    bypassOn        = (test_code_e'(testCode) == TC_BYPASS);
    strobes.refTick = refEn;
    strobes.mTick   = bypassOn ? sclkEn : vcoEn;
    strobes.nTick   = bypassOn ? sclkEn : vcoEn;
  end

endmodule

// File: rtl/testsel_datapath.sv
module testsel_datapath
  import testsel_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int REF_LOG2 = 4,
  parameter int NSEL_W   = 2,
  parameter int Q_LOG2   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  div_strobe_t       strobes,
  input  logic [2:0]        testCode,
  input  logic [M_W-1:0]    mDiv,
  input  logic [NSEL_W-1:0] nSel,
  input  logic              shiftBit,
  output logic              fout,
  output logic              mPulse,
  output logic              testOut
);

  localparam int NMAX_LOG2 = (1 << NSEL_W) - 1;
  localparam int NR_W      = NMAX_LOG2 + 1;

  // Reference prescaler: square wave, period 2**REF_LOG2 ticks.
  logic refDiv;
  generate
    if (REF_LOG2 > 0) begin : g_refPre
      logic [REF_LOG2-1:0] refCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                refCnt <= '0;
        else if (strobes.refTick) refCnt <= refCnt + 1'b1;
      end
      assign refDiv = refCnt[REF_LOG2-1];
    end else begin : g_refPass
      logic refTog;
      always_ff @(posedge clk) begin
        if (!rstN)                refTog <= 1'b0;
        else if (strobes.refTick) refTog <= ~refTog;
      end
      assign refDiv = refTog;
    end
  endgenerate

  // Feedback counter: pulse every mDiv ticks, silent when mDiv is 0.
  logic [M_W-1:0] mCnt;
  logic [M_W-1:0] mLast;
  assign mLast = mDiv - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mCnt   <= '0;
      mPulse <= 1'b0;
    end else if (strobes.mTick && (mDiv != '0)) begin
      if (mCnt >= mLast) begin
        mCnt   <= '0;
        mPulse <= 1'b1;
      end else begin
        mCnt   <= mCnt + 1'b1;
        mPulse <= 1'b0;
      end
    end else begin
      if (mDiv == '0) mCnt <= '0;
      mPulse <= 1'b0;
    end
  end

  // Post divider: fout toggles every 2**nSel ticks.
  logic [NR_W-1:0] nCnt;
  logic [NR_W-1:0] nLast;
  logic            nWrap;
  assign nLast = ({{(NR_W-1){1'b0}}, 1'b1} << nSel) - 1'b1;
  assign nWrap = strobes.nTick && (nCnt >= nLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nCnt <= '0;
      fout <= 1'b0;
    end else if (strobes.nTick) begin
      if (nWrap) begin
        nCnt <= '0;
        fout <= ~fout;
      end else begin
        nCnt <= nCnt + 1'b1;
      end
    end
  end

  // Quarter stage counts fout rising edges.
  logic [Q_LOG2-1:0] qCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                qCnt <= '0;
    else if (nWrap && !fout)  qCnt <= qCnt + 1'b1;
  end

  // Registered source selector.
  logic nextOut;
  always_comb begin
    unique case (test_code_e'(testCode))
      TC_SHIFT:  nextOut = shiftBit;
      TC_ONE:    nextOut = 1'b1;
      TC_REF16:  nextOut = refDiv;
      TC_MCOUNT: nextOut = mPulse;
      TC_FOUT:   nextOut = fout;
      TC_ZERO:   nextOut = 1'b0;
      TC_BYPASS: nextOut = mPulse;
      TC_FOUT4:  nextOut = qCnt[Q_LOG2-1];
      default:   nextOut = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) testOut <= 1'b0;
    else       testOut <= nextOut;
  end

endmodule

// File: rtl/testsel_top.sv
module testsel_top
  import testsel_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int REF_LOG2 = 4,
  parameter int NSEL_W   = 2,
  parameter int Q_LOG2   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoEn,
  input  logic              refEn,
  input  logic              sclkEn,
  input  logic              shiftBit,
  input  logic [2:0]        testCode,
  input  logic [M_W-1:0]    mDiv,
  input  logic [NSEL_W-1:0] nSel,
  output logic              fout,
  output logic              testOut
);

  div_strobe_t strobes;
  logic        mPulse;

  testsel_ctrl u_ctrl (
    .vcoEn    (vcoEn),
    .refEn    (refEn),
    .sclkEn   (sclkEn),
    .testCode (testCode),
    .strobes  (strobes)
  );

  testsel_datapath #(
    .M_W      (M_W),
    .REF_LOG2 (REF_LOG2),
    .NSEL_W   (NSEL_W),
    .Q_LOG2   (Q_LOG2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .testCode (testCode),
    .mDiv     (mDiv),
    .nSel     (nSel),
    .shiftBit (shiftBit),
    .fout     (fout),
    .mPulse   (mPulse),
    .testOut  (testOut)
  );

endmodule

// File: rtl/testsel_checker.sv
module testsel_checker #(
  parameter int M_W = 9
) (
  input logic           clk,
  input logic           rstN,
  input logic [2:0]     testCode,
  input logic [M_W-1:0] mDiv,
  input logic           sclkEn,
  input logic           fout,
  input logic           testOut,
  input logic           mPulse,
  input logic           nTick
);

  // R3
  a_r3_const_one: assert property (@(posedge clk) disable iff (!rstN)
    (testCode == 3'b001) |=> testOut);

  // R3
  a_r3_const_zero: assert property (@(posedge clk) disable iff (!rstN)
    (testCode == 3'b101) |=> !testOut);

  // R5: a pulse is followed by a quiet cycle when M exceeds 1
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (mPulse && (mDiv > 1)) |=> !mPulse);

  // R6
  a_r6_m_zero_silent: assert property (@(posedge clk) disable iff (!rstN)
    (mDiv == '0) |=> !mPulse);

  // R7: the output moves only on a divider tick
  a_r7_fout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !nTick |=> $stable(fout));

  // R9: in bypass, no serial tick means no output movement
  a_r9_bypass_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((testCode == 3'b110) && !sclkEn) |=> $stable(fout));

endmodule

bind testsel_top testsel_checker #(.M_W(M_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .testCode (testCode),
  .mDiv     (mDiv),
  .sclkEn   (sclkEn),
  .fout     (fout),
  .testOut  (testOut),
  .mPulse   (mPulse),
  .nTick    (strobes.nTick)
);

// File: tb/testsel_top_bench.sv
module testsel_top_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       vcoEn, refEn, sclkEn, shiftBit;
  logic [2:0] testCode;
  logic [8:0] mDiv;
  logic [1:0] nSel;
  logic       fout, testOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  testsel_top u_testsel_top (
    .clk(clk), .rstN(rstN), .vcoEn(vcoEn), .refEn(refEn), .sclkEn(sclkEn),
    .shiftBit(shiftBit), .testCode(testCode), .mDiv(mDiv), .nSel(nSel),
    .fout(fout), .testOut(testOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; vcoEn = 0; refEn = 0; sclkEn = 0; shiftBit = 0;
    testCode = 3'b101; mDiv = 9'd0; nSel = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Runs `cycles` clocks with given strobes, then 4 idle clocks; counts
  // fout toggles, testOut toggles, testOut rises and testOut high samples.
  task automatic run(input int cycles, input bit vco, input bit ref_, input int sclkEvery,
                     output int foutTog, output int tTog, output int tRise, output int tHigh);
    logic pf, pt;
    foutTog = 0; tTog = 0; tRise = 0; tHigh = 0;
    pf = fout; pt = testOut;
    for (int i = 0; i < cycles + 4; i++) begin
      @(negedge clk);
      if (fout != pf) foutTog++;
      if (testOut != pt) tTog++;
      if (testOut && !pt) tRise++;
      if (testOut) tHigh++;
      pf = fout; pt = testOut;
      vcoEn  = vco && (i < cycles);
      refEn  = ref_ && (i < cycles);
      sclkEn = (sclkEvery > 0) && (i < cycles) && ((i % sclkEvery) == 0);
    end
  endtask

  task automatic testReset();
    doReset();
    check("R1 fout", fout, 0);
    check("R1 testOut", testOut, 0);
  endtask

  task automatic testShift();
    doReset();
    testCode = 3'b000; shiftBit = 1'b1;
    @(negedge clk); check("R2 shift high", testOut, 1);
    shiftBit = 1'b0;
    @(negedge clk); check("R2 shift low", testOut, 0);
  endtask

  task automatic testConstAndReg();
    doReset();
    testCode = 3'b001;
    @(negedge clk); check("R3 const one", testOut, 1);
    testCode = 3'b101;
    #1 check("R11 unchanged before edge", testOut, 1);
    @(negedge clk); check("R3 const zero", testOut, 0);
  endtask

  task automatic testRef();
    int a, b, c, d;
    doReset();
    testCode = 3'b010;
    run(64, 0, 1, 0, a, b, c, d);
    check("R4 ref/16 toggles", b, 8);
  endtask

  task automatic testMCount();
    int a, b, c, d;
    doReset();
    testCode = 3'b011; mDiv = 9'd5;
    run(50, 1, 0, 0, a, b, c, d);
    check("R5 pulses M=5", c, 10);
    check("R5 width M=5", d, 10);
    doReset();
    testCode = 3'b011; mDiv = 9'd1;
    run(50, 1, 0, 0, a, b, c, d);
    check("R5 high M=1", d, 50);
    doReset();
    testCode = 3'b011; mDiv = 9'd0;
    run(50, 1, 0, 0, a, b, c, d);
    check("R6 no pulse M=0", c, 0);
  endtask

  task automatic testPostDiv();
    int a, b, c, d;
    doReset();
    nSel = 2'd2;
    run(32, 1, 0, 0, a, b, c, d);
    check("R7 ratio 4", a, 8);
    doReset();
    nSel = 2'd3;
    run(32, 1, 0, 0, a, b, c, d);
    check("R7 ratio 8", a, 4);
    doReset();
    testCode = 3'b100; nSel = 2'd1;
    run(16, 1, 0, 0, a, b, c, d);
    check("R8 fout on pin", b, 8);
    doReset();
    testCode = 3'b111; nSel = 2'd0;
    run(64, 1, 0, 0, a, b, c, d);
    check("R8 fout/4 on pin", b, 16);
  endtask

  task automatic testBypass();
    int a, b, c, d;
    doReset();
    testCode = 3'b110; mDiv = 9'd4; nSel = 2'd1;
    run(40, 1, 0, 2, a, b, c, d);
    check("R9 bypass fout toggles", a, 10);
    check("R9 bypass pulses", c, 5);
    doReset();
    testCode = 3'b011; mDiv = 9'd3; nSel = 2'd0;
    run(20, 0, 0, 1, a, b, c, d);
    check("R10 serial ignored fout", a, 0);
    check("R10 serial ignored pulses", c, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testShift();
    testConstAndReg();
    testRef();
    testMCount();
    testPostDiv();
    testBypass();
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule